// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and emits a one-clock pulse at the end of every division cycle. It is intended for the feedback path of a phase-locked loop, where the pulse goes to the phase comparator. Division is split between two parts. A prescaler divides by P or P+1 and is built on a synchronous divide-by-4/5 core followed by divide-by-2 stages. Behind it, a swallow counter `A` and a main counter `B` count prescaler periods. The total ratio is N = B·P + A.

Configuration is written through a single write strobe that carries a prescaler mode, an `A` value and a `B` value. A write is checked first. A legal write is staged and takes effect at the next division-cycle boundary. An illegal write raises an error flag and leaves the staged settings unchanged. At reset the block runs with parameter defaults (mode 0, A = 5, B = 10, so N = 85).

Top module: `psw_fb_divider`

## Requirements
- R1: With settings (P, A, B) active for a whole division cycle, the interval between consecutive `div_pulse` assertions is exactly B·P + A input clocks.
- R2: The mode field selects the prescaler pair: 0 → 8/9, 1 → 16/17, 2 → 32/33, 3 → 64/65 (P = 8 shifted left by the mode value).
- R3: The prescaler is a synchronous divide-by-4/5 core followed by mode+1 divide-by-2 stages. The core state never exceeds 4 and returns to 0 after its terminal state.
- R4: Any `A` from 0 to 63 with A ≤ B is accepted, including A = 0 and A = B.
- R5: `B` values from 3 to 8191 are accepted. A write with B < 3 is rejected like R7.
- R6: In each division cycle the first A prescaler periods last P+1 clocks and the remaining B−A last P. The swallow and main counts change only at the end of a prescaler period.
- R7: A write with A > B or B < 3 sets `cfg_err` on the next clock and leaves the staged configuration unchanged, so the division ratio stays the same.
- R8: A legal write clears `cfg_err` on the next clock.
- R9: New settings take effect only at a division-cycle boundary. The cycle in progress when a write lands completes with the old N, and the next cycle uses the new N.
- R10: `div_pulse` is high for exactly one input clock per division cycle.
- R11: During reset `div_pulse` and `cfg_err` are low. The first `div_pulse` rises exactly N_reset = 85 clocks after reset is released (the pulse is visible after the 85th rising edge).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a new configuration |
| cfg_mode | input | 2 | Prescaler pair select (R2 encoding) |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| div_pulse | output | 1 | One-clock pulse once per N input clocks |
| cfg_err | output | 1 | Set by a rejected write, cleared by a legal one |

## Verification
The bench measures pulse-to-pulse intervals in every prescaler mode, with A = 0 (no period ever stretched), A = B (every period stretched) and the minimum B = 3. A design that let the swallow count slip by one period, or that applied the stretch in the wrong period, would show an interval off by one or by a multiple of P. Writes are made while a cycle is running and the interval that straddles the write is checked. A design that reloaded mid-cycle would produce a mixed interval that matches neither the old N nor the new N. Rejected writes (A > B, B = 2) must raise the flag and leave the interval unchanged. The first pulse after reset is timed to the exact edge.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
  localparam int MODE_W   = 2;
  localparam int A_W      = 6;
  localparam int B_W      = 13;
  localparam int CORE_W   = 3;
  localparam int B_MIN    = 3;

  typedef enum logic [MODE_W-1:0] {
    PS_8_9   = 2'd0,
    PS_16_17 = 2'd1,
    PS_32_33 = 2'd2,
    PS_64_65 = 2'd3
  } ps_mode_e;

  function automatic int unsigned ps_modulus(logic [MODE_W-1:0] m);
    return 32'd8 << m;
  endfunction
endpackage

// File: rtl/psw_core45.sv
`timescale 1ns/1ps
module psw_core45
  import psw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic swallow,
  output logic core_tc
);
  logic [CORE_W-1:0] cnt;
  logic [CORE_W-1:0] term;

  assign term    = swallow ? CORE_W'(4) : CORE_W'(3);
  assign core_tc = (cnt == term);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (core_tc) cnt <= '0;
    else              cnt <= cnt + CORE_W'(1);
  end

  assert_core_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CORE_W'(4));
  assert_core_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    core_tc |=> (cnt == '0));
endmodule

// File: rtl/psw_prescaler.sv
`timescale 1ns/1ps
module psw_prescaler
  import psw_pkg::*;
#(
  parameter int EXT_STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              mc,
  output logic              pre_tc
);
  logic [EXT_STAGES-1:0] stage_q;
  logic [EXT_STAGES-1:0] stage_en;
  logic [EXT_STAGES-1:0] lower_ones;
  logic                  ext_last;
  logic                  core_tc;
  logic                  swallow;

  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < EXT_STAGES; i++) begin
      stage_en[i]   = (i <= int'(mode));
      lower_ones[i] = acc;
      acc           = acc & (stage_q[i] | ~stage_en[i]);
    end
    ext_last = acc;
  end

  assign swallow = mc & ext_last;
  assign pre_tc  = core_tc & ext_last;

  psw_core45 u_core (
    .clk     (clk),
    .rst     (rst),
    .swallow (swallow),
    .core_tc (core_tc)
  );

  for (genvar g = 0; g < EXT_STAGES; g++) begin : g_div2
    always_ff @(posedge clk) begin
      if (rst || !stage_en[g])           stage_q[g] <= 1'b0;
      else if (core_tc && lower_ones[g]) stage_q[g] <= ~stage_q[g];
    end
  end

  assert_pre_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    pre_tc |=> !pre_tc);
endmodule

// File: rtl/psw_cfg.sv
`timescale 1ns/1ps
module psw_cfg
  import psw_pkg::*;
#(
  parameter logic [MODE_W-1:0] RST_MODE = '0,
  parameter logic [A_W-1:0]    RST_A    = A_W'(5),
  parameter logic [B_W-1:0]    RST_B    = B_W'(10)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [A_W-1:0]    wr_a,
  input  logic [B_W-1:0]    wr_b,
  input  logic              boundary,
  output logic [MODE_W-1:0] pend_mode,
  output logic [A_W-1:0]    pend_a,
  output logic [B_W-1:0]    pend_b,
  output logic [MODE_W-1:0] act_mode,
  output logic              err
);
  logic wr_legal;

  assign wr_legal = (wr_b >= B_W'(B_MIN)) &&
                    ({{(B_W-A_W){1'b0}}, wr_a} <= wr_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode <= RST_MODE;
      pend_a    <= RST_A;
      pend_b    <= RST_B;
      act_mode  <= RST_MODE;
      err       <= 1'b0;
    end else begin
      if (we) begin
        if (wr_legal) begin
          pend_mode <= wr_mode;
          pend_a    <= wr_a;
          pend_b    <= wr_b;
          err       <= 1'b0;
        end else begin
          err       <= 1'b1;
        end
      end
      if (boundary) act_mode <= pend_mode;
    end
  end

  assert_legal_pending_R7: assert property (@(posedge clk) disable iff (rst)
    ({{(B_W-A_W){1'b0}}, pend_a} <= pend_b) && (pend_b >= B_W'(B_MIN)));
  assert_reject_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_legal) |=> (err && $stable(pend_a) && $stable(pend_b) && $stable(pend_mode)));
  assert_accept_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (we && wr_legal) |=> !err);
endmodule

// File: rtl/psw_counters.sv
`timescale 1ns/1ps
module psw_counters
  import psw_pkg::*;
#(
  parameter logic [A_W-1:0] RST_A = A_W'(5),
  parameter logic [B_W-1:0] RST_B = B_W'(10)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tc,
  input  logic [A_W-1:0] load_a,
  input  logic [B_W-1:0] load_b,
  output logic           mc,
  output logic           boundary
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;

  assign mc       = (a_rem != '0);
  assign boundary = pre_tc && (b_rem == B_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem <= RST_A;
      b_rem <= RST_B;
    end else if (boundary) begin
      a_rem <= load_a;
      b_rem <= load_b;
    end else if (pre_tc) begin
      b_rem <= b_rem - B_W'(1);
      if (a_rem != '0) a_rem <= a_rem - A_W'(1);
    end
  end

  assert_swallow_order_R6: assert property (@(posedge clk) disable iff (rst)
    {{(B_W-A_W){1'b0}}, a_rem} <= b_rem);
  assert_period_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !pre_tc |=> ($stable(a_rem) && $stable(b_rem)));
  assert_main_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    b_rem != '0);
endmodule

// File: rtl/psw_fb_divider.sv
`timescale 1ns/1ps
module psw_fb_divider
  import psw_pkg::*;
#(
  parameter int                EXT_STAGES = 4,
  parameter logic [MODE_W-1:0] RST_MODE   = '0,
  parameter logic [A_W-1:0]    RST_A      = A_W'(5),
  parameter logic [B_W-1:0]    RST_B      = B_W'(10)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [A_W-1:0]    cfg_a,
  input  logic [B_W-1:0]    cfg_b,
  output logic              div_pulse,
  output logic              cfg_err
);
  logic [MODE_W-1:0] pend_mode;
  logic [A_W-1:0]    pend_a;
  logic [B_W-1:0]    pend_b;
  logic [MODE_W-1:0] act_mode;
  logic              mc;
  logic              pre_tc;
  logic              boundary;

  psw_cfg #(.RST_MODE(RST_MODE), .RST_A(RST_A), .RST_B(RST_B)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wr_mode   (cfg_mode),
    .wr_a      (cfg_a),
    .wr_b      (cfg_b),
    .boundary  (boundary),
    .pend_mode (pend_mode),
    .pend_a    (pend_a),
    .pend_b    (pend_b),
    .act_mode  (act_mode),
    .err       (cfg_err)
  );

  psw_prescaler #(.EXT_STAGES(EXT_STAGES)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .mode   (act_mode),
    .mc     (mc),
    .pre_tc (pre_tc)
  );

  psw_counters #(.RST_A(RST_A), .RST_B(RST_B)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .pre_tc   (pre_tc),
    .load_a   (pend_a),
    .load_b   (pend_b),
    .mc       (mc),
    .boundary (boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= boundary;
  end

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  assert_cfg_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(act_mode));
endmodule

// File: tb/sim_psw_fb_divider.sv
`timescale 1ns/1ps
module sim_psw_fb_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [5:0]  cfg_a = '0;
  logic [12:0] cfg_b = '0;
  logic        div_pulse;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulse_cnt = 0;
  int last_t = 0;
  int prev_t = 0;
  int cur_n = 85;

  always #2.5 clk = ~clk;

  psw_fb_divider u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && div_pulse) begin
      pulse_cnt = pulse_cnt + 1;
      prev_t    = last_t;
      last_t    = cyc;
    end
  end

  function automatic int exp_n(int m, int a, int b);
    return b * (8 << m) + a;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // waits until pulse_cnt reaches target, then checks the pulse drops (R10)
  task automatic wait_count(int target, output int interval);
    int n = 0;
    while (pulse_cnt < target && n < 70000) begin
      @(negedge clk); #1;
      n++;
    end
    if (pulse_cnt < target) begin
      chk(1'b0, "R1 timeout", n, 0);
      interval = -1;
    end else begin
      interval = last_t - prev_t;
      @(negedge clk); #1;
      chk(div_pulse == 1'b0, "R10 pulse width", int'(div_pulse), 0);
    end
  endtask

  task automatic wr_cfg(int m, int a, int b);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_mode = 2'(m);
    cfg_a    = 6'(a);
    cfg_b    = 13'(b);
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run_cfg(int m, int a, int b, string req);
    int c0, i1, i2, nw;
    nw = exp_n(m, a, b);
    wr_cfg(m, a, b);
    chk(cfg_err == 1'b0, "R8 err clear", int'(cfg_err), 0);
    c0 = pulse_cnt;
    wait_count(c0 + 1, i1);
    chk(i1 == cur_n, "R9 old N kept", i1, cur_n);
    wait_count(c0 + 2, i2);
    chk(i2 == nw, req, i2, nw);
    cur_n = nw;
  endtask

  task automatic run_bad(int m, int a, int b, string req);
    int c0, i1, i2;
    wr_cfg(m, a, b);
    chk(cfg_err == 1'b1, req, int'(cfg_err), 1);
    c0 = pulse_cnt;
    wait_count(c0 + 1, i1);
    wait_count(c0 + 2, i2);
    chk(i1 == cur_n && i2 == cur_n, "R7 config held", i2, cur_n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(div_pulse == 1'b0, "R11 pulse in reset", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R11 err in reset", int'(cfg_err), 0);
    rst = 1'b0;
    wait_count(1, t);
    chk(last_t == 85, "R11 first pulse", last_t, 85);
    wait_count(2, t);
    chk(t == 85, "R1 reset N", t, 85);

    // R5 minimum B, R4 A = 0 and A = B at the minimum
    run_cfg(0, 0, 3, "R5 B=3 A=0");
    run_cfg(0, 3, 3, "R4 A=B=3");

    // R2, R4, R6 per mode: A=0, A=B, random A
    for (int m = 0; m < 4; m++) begin
      int b, a;
      b = 3 + int'($urandom_range(0, 27));
      run_cfg(m, 0, b, "R2 A=0 mode");
      b = 3 + int'($urandom_range(0, 17));
      run_cfg(m, b, b, "R6 A=B mode");
      b = 3 + int'($urandom_range(0, 27));
      a = int'($urandom_range(0, b));
      run_cfg(m, a, b, "R1 random");
    end

    // R4 largest A, larger B
    run_cfg(0, 63, 1000, "R4 A=63");

    // R7 A > B rejected; R5 B < 3 rejected
    run_bad(1, 20, 10, "R7 err on A>B");
    run_bad(0, 0, 2, "R5 err on B=2");
    // R8 legal write clears the flag and takes effect
    run_cfg(1, 7, 12, "R8 recovery N");

    summary();
    $finish;
  end
endmodule